// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a master for the two-wire station management bus that configures Ethernet PHYs. Each request becomes one clause-22 frame. A request is a single-cycle start pulse carrying a read/write select, a 5-bit PHY address, a 5-bit register number and, for writes, a 16-bit data word. The block generates the management clock, drives the data line during the parts of the frame it owns, and releases the line during turnaround and read data. For reads, it collects the sixteen bits the PHY returns.

Every frame is 64 bit times long. Each bit time has a low half and a high half of the management clock, and each half lasts `HALF_DIV` system clocks. Output data changes only at the start of a low half. The input line is sampled on the last system clock of the high half. `busy_o` marks a frame in progress. `done_o` pulses once when the frame is over, and at that moment `rdata_o` holds the word that was read.

The shape of a read frame differs from that of a write frame. A read releases the line for one turnaround bit and then samples sixteen data bits. It ends with one more released clock. A write releases the line for two bit times and then drives its sixteen data bits.

Top module: `mdio_master`

## Requirements
- R1: During reset, and in the cycle after it is released, `busy_o`, `done_o`, `mdc_o`, `mdio_o` and `mdio_oe_o` are all 0.
- R2: Bit times 0 to 31 of every frame are driven high (`mdio_oe_o`=1, `mdio_o`=1).
- R3: Bit times 32 and 33 are driven 0 then 1. Bit times 34 and 35 are driven 0,1 for a write (`wr_i`=1) and 1,0 for a read (`wr_i`=0).
- R4: Bit times 36 to 40 drive `phy_i` and bit times 41 to 45 drive `reg_i`, each most significant bit first.
- R5: In a write frame, bit times 46 and 47 are released (`mdio_oe_o`=0, `mdio_o`=0), and bit times 48 to 63 drive `wdata_i` MSB first. Whenever the output is released, `mdio_o` is 0.
- R6: In a read frame, bit times 46 to 63 are all released: one turnaround bit, sixteen data bits and one trailing clock.
- R7: Within a bit time, `mdc_o` is low for exactly `HALF_DIV` clocks and then high for exactly `HALF_DIV` clocks. `mdio_o` and `mdio_oe_o` do not change while `mdc_o` is high.
- R8: In a read, the value of `mdio_i` during the high halves of bit times 47 to 62 forms `rdata_o`, with bit 47 as the MSB. This word is valid when `done_o` is high.
- R9: A start accepted while idle raises `busy_o` on the next clock. `done_o` is a one-cycle pulse, 1+128·`HALF_DIV` clocks after the start cycle, and `busy_o` falls in that same cycle.
- R10: Whenever `busy_o` is low, `mdc_o`, `mdio_o` and `mdio_oe_o` are 0.
- R11: A start pulse while `busy_o` is high is ignored. The running frame keeps its fields and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a frame |
| wr_i | input | 1 | 1 = write frame, 0 = read frame |
| phy_i | input | 5 | PHY address |
| reg_i | input | 5 | Register number |
| wdata_i | input | 16 | Data for a write |
| rdata_o | output | 16 | Word captured by the last read |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line as seen from the bus |

## Verification
A bit index that slips by one moves an entire field. The bench sees this at the first rising clock of the affected field and compares every bit time against a frame built in the bench. A divider or half-phase error changes the length of the very first clock low half, so it shows within `HALF_DIV` cycles of the start. A misplaced capture window or reversed shift shows in `rdata_o` at `done_o`, 128·`HALF_DIV` clocks later. The bench sweeps every address value, walking-one data and read responses to catch it there. A sequencer that does not hold its fields while busy shows as a changed frame, or as a second `done_o`, after a start pulse is injected mid-frame.

// File: rtl/mdio_pkg.sv
// Shared constants and types for the management frame master.
// Offsets are counted in bit times from the end of the preamble.
package mdio_pkg;
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned DATA_W   = 16;
    localparam int unsigned BODY_LEN = 32;
    localparam int unsigned OFS_ST   = 0;
    localparam int unsigned OFS_OP   = 2;
    localparam int unsigned OFS_PHY  = 4;
    localparam int unsigned OFS_REG  = OFS_PHY + ADDR_W;
    localparam int unsigned OFS_WDAT = 16;
    localparam int unsigned OFS_RDAT = 15;

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } mdio_opc_e;
endpackage

// File: rtl/mdio_tick.sv
// Half-period divider: pulses tick on every HALF_DIV-th clock while run is high.
// Assumes run rises on the clock after a start is accepted; the count restarts from zero whenever run is low.
module mdio_tick #(
    parameter int unsigned HALF_DIV = 4,
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

    // Count system clocks within one MDC half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_build.sv
// Builds the drive value and output-enable for every bit time of one frame.
// Index 0 is the first bit on the wire. Purely combinational; the caller registers the result at start.
module mdio_frame_build
    import mdio_pkg::*;
#(
    parameter int unsigned PRE_LEN = 32,
    localparam int unsigned FRAME_LEN = PRE_LEN + BODY_LEN
) (
    input  logic                 is_wr,
    input  logic [ADDR_W-1:0]    phy,
    input  logic [ADDR_W-1:0]    regad,
    input  logic [DATA_W-1:0]    wdata,
    output logic [FRAME_LEN-1:0] drv_v,
    output logic [FRAME_LEN-1:0] oe_v
);
    mdio_opc_e opc;

    assign opc = is_wr ? OPC_WRITE : OPC_READ;

    // Lay out preamble, start, opcode, addresses and write data into the frame vectors.
    always_comb begin
        drv_v = '0;
        oe_v  = '0;
        for (int i = 0; i < int'(PRE_LEN); i++) begin
            drv_v[i] = 1'b1;
            oe_v[i]  = 1'b1;
        end
        for (int i = 0; i < 4; i++) begin
            oe_v[PRE_LEN + OFS_ST + i] = 1'b1;
        end
        drv_v[PRE_LEN + OFS_ST]     = 1'b0;
        drv_v[PRE_LEN + OFS_ST + 1] = 1'b1;
        drv_v[PRE_LEN + OFS_OP]     = opc[1];
        drv_v[PRE_LEN + OFS_OP + 1] = opc[0];
        for (int k = 0; k < int'(ADDR_W); k++) begin
            drv_v[PRE_LEN + OFS_PHY + k] = phy[ADDR_W - 1 - k];
            oe_v[PRE_LEN + OFS_PHY + k]  = 1'b1;
            drv_v[PRE_LEN + OFS_REG + k] = regad[ADDR_W - 1 - k];
            oe_v[PRE_LEN + OFS_REG + k]  = 1'b1;
        end
        if (is_wr) begin
            for (int k = 0; k < int'(DATA_W); k++) begin
                drv_v[PRE_LEN + OFS_WDAT + k] = wdata[DATA_W - 1 - k];
                oe_v[PRE_LEN + OFS_WDAT + k]  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_capture.sv
// Shift register collecting read data MSB first.
// Assumes shift_en is high exactly once per sampled bit, at the end of the MDC high half.
module mdio_capture
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              din,
    output logic [DATA_W-1:0] word
);
    // Clear on frame start, shift in one sampled bit per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[DATA_W-2:0], din};
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Clause-22 management frame master.
// A start accepted while idle loads the whole frame into two vectors (drive level and enable).
// A bit index then walks them, one bit time per pair of MDC halves. Starts that arrive while busy are dropped.
// Assumes mdio_i has been synchronized externally, or that it is stable during the MDC high half.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int unsigned HALF_DIV = 4,
    parameter int unsigned PRE_LEN  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] phy_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    localparam int unsigned FRAME_LEN = PRE_LEN + BODY_LEN;
    localparam int unsigned IW        = $clog2(FRAME_LEN);
    localparam int unsigned CAP_FIRST = PRE_LEN + OFS_RDAT;
    localparam int unsigned CAP_LAST  = CAP_FIRST + DATA_W - 1;

    logic                 busy_q, hi_q, rd_q, done_q;
    logic [IW-1:0]        idx_q;
    logic [FRAME_LEN-1:0] drv_q, oe_q, drv_n, oe_n;
    logic [DATA_W-1:0]    rdata_q, cap_word;
    logic                 tick, accept, last_bit, in_win, end_bit, cap_en;

    assign accept   = start_i && !busy_q;
    assign last_bit = (idx_q == IW'(FRAME_LEN - 1));
    assign in_win   = (idx_q >= IW'(CAP_FIRST)) && (idx_q <= IW'(CAP_LAST));
    assign end_bit  = tick && hi_q;
    assign cap_en   = end_bit && rd_q && in_win;

    mdio_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy_q),
        .tick (tick)
    );

    mdio_frame_build #(.PRE_LEN(PRE_LEN)) u_build (
        .is_wr(wr_i),
        .phy  (phy_i),
        .regad(reg_i),
        .wdata(wdata_i),
        .drv_v(drv_n),
        .oe_v (oe_n)
    );

    mdio_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .shift_en(cap_en),
        .din     (mdio_i),
        .word    (cap_word)
    );

    // Frame sequencer: accept, walk half periods and bit times, end with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            hi_q   <= 1'b0;
            rd_q   <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= '0;
            drv_q  <= '0;
            oe_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                hi_q   <= 1'b0;
                idx_q  <= '0;
                rd_q   <= !wr_i;
                drv_q  <= drv_n;
                oe_q   <= oe_n;
            end else if (busy_q && tick) begin
                if (!hi_q) begin
                    hi_q <= 1'b1;
                end else begin
                    hi_q <= 1'b0;
                    if (last_bit) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            end
        end
    end

    // Read result register, updated at the end of a read frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (end_bit && last_bit && rd_q) begin
            rdata_q <= cap_word;
        end
    end

    assign busy_o    = busy_q;
    assign done_o    = done_q;
    assign rdata_o   = rdata_q;
    assign mdc_o     = busy_q && hi_q;
    assign mdio_oe_o = busy_q && oe_q[idx_q];
    assign mdio_o    = busy_q && oe_q[idx_q] && drv_q[idx_q];
endmodule

// File: rtl/mdio_master_chk.sv
// Port-level protocol checker for mdio_master, attached by bind below.
// Assumes the synchronous active-low reset; all properties are disabled while it is low.
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic mdc_o,
    input logic mdio_o,
    input logic mdio_oe_o
);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_o && !mdio_o && !mdio_oe_o));

    p_released_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_oe_o |-> !mdio_o);

    p_stable_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_busy_ends_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .mdc_o    (mdc_o),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o)
);

// File: tb/sim_mdio_master.sv
// Bench for mdio_master with HALF_DIV=2. Each frame is compared bit time by bit time
// against a frame computed here, and a PHY response is modelled for reads.
module sim_mdio_master;
    localparam int HALF = 2;
    localparam int NB   = 64;
    localparam int DONE_AT = 1 + 128 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, wr_i = 1'b0, mdio_i = 1'b0;
    logic [4:0]  phy_i = '0, reg_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;

    int checks = 0;
    int errors = 0;
    logic obs_out [NB];
    logic obs_oe  [NB];

    always #10 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF), .PRE_LEN(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i),
        .phy_i(phy_i), .reg_i(reg_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .busy_o(busy_o), .done_o(done_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
        .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected {enable, level} of bit time i.
    function automatic logic [1:0] exp_bit(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [15:0] wd, input int i);
        if (i < 32) return 2'b11;
        if (i == 32) return 2'b10;
        if (i == 33) return 2'b11;
        if (i == 34) return wr ? 2'b10 : 2'b11;
        if (i == 35) return wr ? 2'b11 : 2'b10;
        if (i <= 40) return {1'b1, phy[40 - i]};
        if (i <= 45) return {1'b1, rg[45 - i]};
        if (wr && i >= 48) return {1'b1, wd[63 - i]};
        return 2'b00;
    endfunction

    task automatic region(input bit wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd,
                          input int lo, input int hi, input string tag);
        int bad = 0;
        for (int i = lo; i <= hi; i++) begin
            if ({obs_oe[i], obs_out[i]} !== exp_bit(wr, phy, rg, wd, i)) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic run_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic [15:0] resp, input bit inject);
        int c = 0, b = 0, run = 0, tbad = 0, sbad = 0, done_c = 0;
        logic pm = 1'b0;
        logic [15:0] got = '0;
        for (int i = 0; i < NB; i++) begin obs_out[i] = 1'bx; obs_oe[i] = 1'bx; end
        @(negedge clk);
        start_i = 1'b1; wr_i = wr; phy_i = phy; reg_i = rg; wdata_i = wd;
        while (c < DONE_AT + 40 && done_c == 0) begin
            @(negedge clk);
            c++;
            if (c == 1) start_i = 1'b0;
            if (inject && c == 40) begin
                start_i = 1'b1; wr_i = !wr; phy_i = ~phy; reg_i = ~rg; wdata_i = ~wd;
            end
            if (inject && c == 41) start_i = 1'b0;
            if (c == 1) chk(busy_o === 1'b1, "R9 busy after start", busy_o, 1);
            if (done_o) begin
                done_c = c;
                got = rdata_o;
                if (run != HALF) tbad++;
                chk(!mdc_o && !mdio_oe_o && !mdio_o, "R10 idle lines at done", {mdc_o, mdio_oe_o, mdio_o}, 0);
            end else if (busy_o) begin
                if (mdc_o == pm) run++;
                else begin
                    if (run != HALF) tbad++;
                    run = 1;
                end
                if (mdc_o && !pm) begin
                    if (b < NB) begin obs_out[b] = mdio_o; obs_oe[b] = mdio_oe_o; end
                    if (!wr && b >= 47 && b <= 62) mdio_i = resp[62 - b];
                    else mdio_i = b[0];
                    b++;
                end else if (mdc_o && pm && b > 0 && b <= NB) begin
                    if (mdio_o !== obs_out[b-1] || mdio_oe_o !== obs_oe[b-1]) sbad++;
                end
                pm = mdc_o;
            end
        end
        if (done_c == 0) chk(1'b0, "R9 done never seen", 0, 1);
        chk(done_c == DONE_AT, "R9 done timing", done_c, DONE_AT);
        chk(b == NB, "R6 bit times per frame", b, NB);
        chk(tbad == 0, "R7 MDC half lengths", tbad, 0);
        chk(sbad == 0, "R7 data stable while MDC high", sbad, 0);
        region(wr, phy, rg, wd, 0, 31, "R2 preamble");
        region(wr, phy, rg, wd, 32, 35, "R3 start and opcode");
        region(wr, phy, rg, wd, 36, 45, "R4 addresses");
        if (wr) region(wr, phy, rg, wd, 46, 63, "R5 turnaround and write data");
        else begin
            region(wr, phy, rg, wd, 46, 63, "R6 read release");
            chk(got === resp, "R8 read data", got, resp);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!done_o && !busy_o && !mdc_o && !mdio_oe_o && !mdio_o,
                inject ? "R11 no second frame" : "R10 idle after frame",
                {done_o, busy_o, mdc_o, mdio_oe_o, mdio_o}, 0);
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(!busy_o && !done_o && !mdc_o && !mdio_o && !mdio_oe_o, "R1 outputs in reset",
            {busy_o, done_o, mdc_o, mdio_o, mdio_oe_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !mdc_o && !mdio_o && !mdio_oe_o, "R1 outputs after reset",
            {busy_o, done_o, mdc_o, mdio_o, mdio_oe_o}, 0);
        chk(rdata_o === 16'h0, "R1 read data after reset", rdata_o, 0);
        // Write sweep over all PHY addresses and register numbers (R4, R5).
        for (int a = 0; a < 32; a++)
            run_frame(1'b1, 5'(a), 5'(31 - a), 16'hA5C3 ^ 16'(a * 16'h0911), 16'h0, 1'b0);
        // Read sweep with distinct responses (R6, R8).
        for (int a = 0; a < 32; a++)
            run_frame(1'b0, 5'(a ^ 31), 5'(a), 16'hFFFF, 16'h1234 + 16'(a * 16'h0F0F), 1'b0);
        // Walking one in data and in the response.
        for (int k = 0; k < 16; k++) begin
            run_frame(1'b1, 5'(k), 5'(k), 16'(1) << k, 16'h0, 1'b0);
            run_frame(1'b0, 5'(k), 5'(k), 16'h0, 16'(1) << k, 1'b0);
        end
        // Extreme data values.
        run_frame(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 16'h0, 1'b0);
        run_frame(1'b1, 5'h00, 5'h00, 16'h0000, 16'h0, 1'b0);
        run_frame(1'b0, 5'h00, 5'h1F, 16'h0, 16'hFFFF, 1'b0);
        run_frame(1'b0, 5'h1F, 5'h00, 16'h0, 16'h0000, 1'b0);
        // R11: start pulses during a frame are ignored.
        run_frame(1'b1, 5'h0A, 5'h15, 16'h3C96, 16'h0, 1'b1);
        run_frame(1'b0, 5'h15, 5'h0A, 16'h0, 16'hC35A, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule